// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller

This block connects a simple valid/ready request port to an asynchronous DRAM whose address pins are shared between the row and the column. Each request address is split into an upper row field and a lower column field. Both fields go out on one narrow address bus, one after the other, qualified by an active-low row strobe and an active-low column strobe. Output-enable and write-enable strobes are derived from the request direction. All DRAM timing (row-to-column delay, access time, column pulse width, precharge, full cycle time) is set by parameters counted in clock cycles.

After an access the row is left open. A later request to the same row only pulses the column strobe and skips the slow row activation. A request to a different row first closes the open row, observing the minimum row-active and precharge times, and then activates the new row. A built-in refresh scheduler raises a request once per interval and walks a row counter through every row. A pending refresh blocks new requests, closes any open row, and activates the counted row with the column strobe held high.

Top module: `dram_mux_ctrl`

## Requirements
- R1: During and after reset all four DRAM strobes are high (inactive), the data bus is not driven, `rsp_valid` is low and `req_ready` is high.
- R2: A row-miss access drives the row field (address bits [ROW_W+COL_W-1:COL_W]) and drops the row strobe. Exactly T_RCD cycles later it drives the column field (bits [COL_W-1:0]) and drops the column strobe.
- R3: Read data is captured no earlier than T_RAC cycles after the row strobe fell, and with the column strobe low for at least T_CAS cycles. It is returned as a one-cycle `rsp_valid` pulse carrying the word stored at that address. Writes produce no response.
- R4: A request to the row that is currently open toggles only the column strobe, and the row strobe stays low. A request to any other row, and the first access after a refresh, performs a new row activation.
- R5: Between a rise and the next fall of the row strobe there are at least T_RP cycles. Between two falls there are at least T_RC cycles.
- R6: During a write the write strobe is low, the output enable is high and the data bus is driven with the request data for the whole column pulse. During a read the output enable is low, the write strobe is high and the bus is released.
- R7: A refresh activation (row strobe low, column strobe never low) occurs once per REF_INT cycles, give or take the time to finish the access in progress. Refresh rows come in ascending order from row 0, wrapping modulo 2**ROW_W, so every row is refreshed within 2**ROW_W intervals.
- R8: A pending refresh takes priority over new requests. Even under a continuous stream of same-row requests, refreshes keep to the interval of R7.
- R9: `req_ready` is low while a column access is in progress and in the cycle after a request is accepted.
- R10: The column strobe is only ever low while the row strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address: row in upper bits, column in lower bits |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | DATA_W | Read data |
| mem_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address to DRAM |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | DATA_W | Data driven to DRAM |
| mem_dq_oe | output | 1 | 1 = controller drives mem_dq_out |
| mem_dq_in | input | DATA_W | Data returned by DRAM |

## Verification
The assertions assume that the requester holds its fields stable while `req_valid` is high and not yet accepted. They also assume that the DRAM returns valid data on `mem_dq_in` whenever both the column strobe and the output enable are low. The bench issues requests only through a task that keeps the fields steady until it sees `req_ready`, and its DRAM model answers combinationally from the latched row and the current column. The parameters are chosen with T_RAC greater than T_RCD and T_RC greater than T_RP, which the timing counters in the checker rely on.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ACT,
    S_COL,
    S_OPEN,
    S_CLOSE,
    S_PRECH,
    S_REF
  } dmc_state_e;

  function automatic int unsigned imax2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dmc_refresh_sched.sv
module dmc_refresh_sched #(
  parameter int ROW_W   = 13,
  parameter int REF_INT = 240
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_take,
  output logic             ref_pend,
  output logic [ROW_W-1:0] ref_row
);
  localparam int TW = $clog2(REF_INT);
  localparam logic [TW-1:0] T_LAST = TW'(REF_INT - 1);

  logic [TW-1:0] tmr;

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr      <= '0;
      ref_pend <= 1'b0;
      ref_row  <= '0;
    end else begin
      tmr <= (tmr == T_LAST) ? '0 : tmr + 1'b1;
      if (ref_take) begin
        ref_pend <= 1'b0;
        ref_row  <= ref_row + 1'b1;
      end
      if (tmr == T_LAST) ref_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/dmc_page_tracker.sv
module dmc_page_tracker #(
  parameter int ROW_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pg_set,
  input  logic [ROW_W-1:0] pg_set_row,
  input  logic             pg_clr,
  input  logic [ROW_W-1:0] cmp_row,
  output logic             pg_hit
);
  logic             open_vld;
  logic [ROW_W-1:0] open_row;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_vld <= 1'b0;
      open_row <= '0;
    end else if (pg_set) begin
      open_vld <= 1'b1;
      open_row <= pg_set_row;
    end else if (pg_clr) begin
      open_vld <= 1'b0;
    end
  end

  assign pg_hit = open_vld && (open_row == cmp_row);
endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl
  import dmc_pkg::*;
#(
  parameter int ROW_W   = 13,
  parameter int COL_W   = 13,
  parameter int DATA_W  = 16,
  parameter int T_RCD   = 3,
  parameter int T_RAC   = 10,
  parameter int T_CAS   = 4,
  parameter int T_RP    = 6,
  parameter int T_RC    = 18,
  parameter int REF_INT = 240,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [MA_W-1:0]   mem_addr,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int T_RAS  = T_RC - T_RP;
  localparam int CW     = $clog2(T_RC + 1);
  localparam int PH_MAX = imax2(imax2(T_RCD, T_CAS), imax2(T_RP, T_RAC));
  localparam int PW     = $clog2(PH_MAX + 1);

  dmc_state_e        state;
  logic [PW-1:0]     ph;
  logic [CW-1:0]     ras_cnt;
  logic              h_wr, h_pend;
  logic [ADDR_W-1:0] h_addr;
  logic [DATA_W-1:0] h_wdata;

  logic              ref_pend, ref_take;
  logic [ROW_W-1:0]  ref_row;
  logic              pg_hit, pg_set, pg_clr;
  logic [ROW_W-1:0]  req_row, h_row, pg_set_row;

  logic acc_idle, acc_open, act_done, col_done, prech_done, ras_min_ok, go_col;
  logic              c_wr;
  logic [COL_W-1:0]  c_col;
  logic [DATA_W-1:0] c_wdata;

  assign req_row = req_addr[ADDR_W-1 -: ROW_W];
  assign h_row   = h_addr[ADDR_W-1 -: ROW_W];

  // Transition conditions shared by the sequencer and the helpers
  assign acc_idle   = (state == S_IDLE) && !ref_pend && req_valid;
  assign acc_open   = (state == S_OPEN) && !ref_pend && req_valid;
  assign act_done   = (state == S_ACT) && (ph == PW'(T_RCD - 1));
  assign col_done   = (state == S_COL) && (ph >= PW'(T_CAS - 1)) && (ras_cnt >= CW'(T_RAC - 1));
  assign prech_done = (state == S_PRECH) && (ph == PW'(T_RP - 1));
  assign ras_min_ok = ras_cnt >= CW'(T_RAS - 1);
  assign go_col     = act_done || (acc_open && pg_hit);

  assign ref_take   = ((state == S_IDLE) && ref_pend) || (prech_done && !h_pend && ref_pend);
  assign pg_set     = acc_idle || (prech_done && h_pend);
  assign pg_set_row = acc_idle ? req_row : h_row;
  assign pg_clr     = (state == S_CLOSE) && ras_min_ok;

  // Column launch source: live request on a page hit, held request otherwise
  assign c_wr    = (state == S_OPEN) ? req_write : h_wr;
  assign c_col   = (state == S_OPEN) ? req_addr[COL_W-1:0] : h_addr[COL_W-1:0];
  assign c_wdata = (state == S_OPEN) ? req_wdata : h_wdata;

  assign req_ready = ((state == S_IDLE) || (state == S_OPEN)) && !ref_pend;

  dmc_refresh_sched #(.ROW_W(ROW_W), .REF_INT(REF_INT)) u_ref (
    .clk(clk), .rst(rst), .ref_take(ref_take), .ref_pend(ref_pend), .ref_row(ref_row)
  );

  dmc_page_tracker #(.ROW_W(ROW_W)) u_page (
    .clk(clk), .rst(rst), .pg_set(pg_set), .pg_set_row(pg_set_row),
    .pg_clr(pg_clr), .cmp_row(req_row), .pg_hit(pg_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      ph         <= '0;
      ras_cnt    <= '0;
      mem_addr   <= '0;
      mem_ras_n  <= 1'b1;
      mem_cas_n  <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      h_wr       <= 1'b0;
      h_pend     <= 1'b0;
      h_addr     <= '0;
      h_wdata    <= '0;
    end else begin
      rsp_valid <= 1'b0;
      ras_cnt   <= mem_ras_n ? '0 : ((ras_cnt == CW'(T_RC)) ? ras_cnt : ras_cnt + 1'b1);
      ph        <= (ph == PW'(PH_MAX)) ? ph : ph + 1'b1;

      if (acc_idle || acc_open) begin
        h_wr    <= req_write;
        h_addr  <= req_addr;
        h_wdata <= req_wdata;
      end

      unique case (state)
        S_IDLE: begin
          if (ref_pend) begin
            state     <= S_REF;
            ph        <= '0;
            mem_ras_n <= 1'b0;
            mem_addr  <= MA_W'(ref_row);
          end else if (acc_idle) begin
            state     <= S_ACT;
            ph        <= '0;
            mem_ras_n <= 1'b0;
            mem_addr  <= MA_W'(req_row);
          end
        end
        S_ACT: if (act_done) begin
          state <= S_COL;
          ph    <= '0;
        end
        S_COL: if (col_done) begin
          state     <= S_OPEN;
          ph        <= '0;
          mem_cas_n <= 1'b1;
          mem_we_n  <= 1'b1;
          mem_oe_n  <= 1'b1;
          mem_dq_oe <= 1'b0;
          rsp_valid <= !h_wr;
          if (!h_wr) rsp_rdata <= mem_dq_in;
        end
        S_OPEN: begin
          if (ref_pend) begin
            state <= S_CLOSE;
            ph    <= '0;
          end else if (acc_open) begin
            ph <= '0;
            if (pg_hit) state <= S_COL;
            else begin
              state  <= S_CLOSE;
              h_pend <= 1'b1;
            end
          end
        end
        S_CLOSE, S_REF: if (ras_min_ok) begin
          state     <= S_PRECH;
          ph        <= '0;
          mem_ras_n <= 1'b1;
        end
        S_PRECH: if (prech_done) begin
          ph <= '0;
          if (h_pend) begin
            h_pend    <= 1'b0;
            state     <= S_ACT;
            mem_ras_n <= 1'b0;
            mem_addr  <= MA_W'(h_row);
          end else if (ref_pend) begin
            state     <= S_REF;
            mem_ras_n <= 1'b0;
            mem_addr  <= MA_W'(ref_row);
          end else begin
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase

      if (go_col) begin
        mem_cas_n  <= 1'b0;
        mem_addr   <= MA_W'(c_col);
        mem_we_n   <= !c_wr;
        mem_oe_n   <= c_wr;
        mem_dq_oe  <= c_wr;
        mem_dq_out <= c_wdata;
      end
    end
  end
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
  parameter int T_RP  = 6,
  parameter int T_RC  = 18,
  parameter int T_RAC = 10,
  parameter int T_CAS = 4
) (
  input logic clk,
  input logic rst,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic oe_n,
  input logic req_ready,
  input logic rsp_valid
);
  logic [15:0] hi_run, lo_run, since_fall, cas_cnt, cas_len;
  logic        prev_ras;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_run     <= 16'(T_RP);
      lo_run     <= '0;
      since_fall <= 16'(T_RC);
      cas_cnt    <= '0;
      cas_len    <= '0;
      prev_ras   <= 1'b1;
    end else begin
      prev_ras   <= ras_n;
      hi_run     <= ras_n ? ((hi_run == 16'hFFFF) ? hi_run : hi_run + 1'b1) : '0;
      lo_run     <= ras_n ? '0 : ((lo_run == 16'hFFFF) ? lo_run : lo_run + 1'b1);
      since_fall <= (prev_ras && !ras_n) ? 16'd1 :
                    ((since_fall == 16'hFFFF) ? since_fall : since_fall + 1'b1);
      cas_cnt    <= cas_n ? '0 : cas_cnt + 1'b1;
      if (!cas_n) cas_len <= cas_cnt + 1'b1;
    end
  end

  // R5: precharge time before every activation
  p_precharge_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> hi_run >= 16'(T_RP));

  // R5: full row cycle time between activations
  p_row_cycle_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> since_fall >= 16'(T_RC));

  // R3: read data returned only after access time and column pulse width
  p_access_time_r3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (!ras_n && lo_run >= 16'(T_RAC)));

  p_cas_width_r3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> cas_len >= 16'(T_CAS));

  p_rsp_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R6: write strobe only inside a column pulse and never with output enable
  p_we_in_cas_r6: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (!cas_n && oe_n));

  // R9: port not ready during a column access
  p_ready_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> cas_n);

  // R10: column strobe only under an active row strobe
  p_cas_in_ras_r10: assert property (@(posedge clk) disable iff (rst)
    !cas_n |-> !ras_n);
endmodule

bind dram_mux_ctrl dmc_checker #(
  .T_RP(T_RP), .T_RC(T_RC), .T_RAC(T_RAC), .T_CAS(T_CAS)
) u_dmc_chk (
  .clk(clk), .rst(rst), .ras_n(mem_ras_n), .cas_n(mem_cas_n),
  .we_n(mem_we_n), .oe_n(mem_oe_n), .req_ready(req_ready), .rsp_valid(rsp_valid)
);

// File: tb/dram_mux_ctrl_tb_top.sv
`timescale 1ns/1ps
module dram_mux_ctrl_tb_top;
  localparam int ROW_W = 3, COL_W = 3, DATA_W = 8;
  localparam int T_RCD = 2, T_RAC = 4, T_CAS = 2, T_RP = 2, T_RC = 7, REF_INT = 120;
  localparam int ADDR_W = ROW_W + COL_W, MA_W = 3, ROWS = 1 << ROW_W, WORDS = 1 << ADDR_W;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0, req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0, rsp_rdata, mem_dq_out, mem_dq_in;
  logic rsp_valid, mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [MA_W-1:0] mem_addr;

  always #2.5 clk = ~clk;

  dram_mux_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RCD(T_RCD), .T_RAC(T_RAC),
    .T_CAS(T_CAS), .T_RP(T_RP), .T_RC(T_RC), .REF_INT(REF_INT)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  int n_chk = 0, n_fail = 0, cyc = 0, n_ref = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // DRAM model
  logic [DATA_W-1:0] model_mem [0:WORDS-1];
  logic [ROW_W-1:0]  lat_row = '0;
  assign mem_dq_in = (!mem_oe_n && !mem_cas_n) ? model_mem[{lat_row, mem_addr[COL_W-1:0]}] : 8'hEE;

  // Bench shadow and queues
  logic [DATA_W-1:0] shadow [0:WORDS-1];
  int q_addr [0:255], q_d [0:255], rq [0:255];
  bit q_wr [0:255];
  int qh = 0, qt = 0, rh = 0, rt = 0;
  int ref_time [0:ROWS-1];

  bit p_ras = 1, p_cas = 1, cas_seen = 1, ref_seen = 0, have_prev = 0, acc_prev = 0;
  int rise_cyc = -100, last_fall = -100, cas_start = 0, last_ref_fall = 0, exp_ref = 0;
  logic [ROW_W-1:0] prev_row = '0;

  always @(negedge clk) begin
    if (!rst && !done) begin
      cyc++;
      if (p_ras && !mem_ras_n) begin
        chk(cyc - rise_cyc >= T_RP, "R5 precharge cycles", cyc - rise_cyc, T_RP);
        chk(cyc - last_fall >= T_RC, "R5 row cycle", cyc - last_fall, T_RC);
        last_fall = cyc;
        lat_row   = mem_addr[ROW_W-1:0];
        cas_seen  = 0;
      end
      if (!p_ras && mem_ras_n) begin
        rise_cyc = cyc;
        if (!cas_seen) begin
          chk(int'(lat_row) == exp_ref, "R7 refresh row order", int'(lat_row), exp_ref);
          if (n_ref > 0)
            chk((last_fall - last_ref_fall <= REF_INT + 20) && (last_fall - last_ref_fall >= REF_INT - 20),
                "R7/R8 refresh interval", last_fall - last_ref_fall, REF_INT);
          last_ref_fall = last_fall;
          ref_time[lat_row] = cyc;
          exp_ref = (exp_ref + 1) % ROWS;
          n_ref++;
          ref_seen = 1;
        end
      end
      if (p_cas && !mem_cas_n) begin
        int a;
        bit miss, exp_miss;
        cas_start = cyc;
        if (!cas_seen) chk(cyc - last_fall == T_RCD, "R2 row-to-column delay", cyc - last_fall, T_RCD);
        miss     = !cas_seen;
        exp_miss = !have_prev || (lat_row != prev_row) || ref_seen;
        chk(miss == exp_miss, "R4 page hit/miss", miss, exp_miss);
        have_prev = 1; prev_row = lat_row; ref_seen = 0; cas_seen = 1;
        a = int'({lat_row, mem_addr[COL_W-1:0]});
        chk(qh != qt, "R2 access without request", 0, 1);
        chk(a == q_addr[qh], "R2 row/column address", a, q_addr[qh]);
        if (q_wr[qh]) begin
          chk(!mem_we_n && mem_oe_n && mem_dq_oe, "R6 write strobes", {mem_we_n, mem_oe_n, mem_dq_oe}, 3'b011);
          chk(int'(mem_dq_out) == q_d[qh], "R6 write data", int'(mem_dq_out), q_d[qh]);
          model_mem[a] = mem_dq_out;
        end else begin
          chk(mem_we_n && !mem_oe_n && !mem_dq_oe, "R6 read strobes", {mem_we_n, mem_oe_n, mem_dq_oe}, 3'b100);
        end
        qh = (qh + 1) % 256;
      end
      if (!p_cas && mem_cas_n) chk(cyc - cas_start >= T_CAS, "R3 column pulse width", cyc - cas_start, T_CAS);
      if (!mem_cas_n) begin
        chk(!mem_ras_n, "R10 column strobe under row strobe", mem_ras_n, 0);
        chk(!req_ready, "R9 ready during column access", req_ready, 0);
      end
      if (rsp_valid) begin
        chk(rh != rt, "R3 unexpected response", 1, 0);
        chk(int'(rsp_rdata) == rq[rh], "R3 read data", int'(rsp_rdata), rq[rh]);
        chk(cyc - last_fall >= T_RAC, "R3 access time", cyc - last_fall, T_RAC);
        rh = (rh + 1) % 256;
      end
      if (acc_prev) chk(!req_ready, "R9 ready after accept", req_ready, 0);
      acc_prev = req_valid && req_ready;
      if (acc_prev) begin
        q_addr[qt] = int'(req_addr); q_d[qt] = int'(req_wdata); q_wr[qt] = req_write;
        qt = (qt + 1) % 256;
        if (!req_write) begin
          rq[rt] = int'(shadow[req_addr]);
          rt = (rt + 1) % 256;
        end
      end
      p_ras = mem_ras_n;
      p_cas = mem_cas_n;
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic issue(input bit wr, input int a, input int d);
    req_valid = 1; req_write = wr;
    req_addr = ADDR_W'(a); req_wdata = DATA_W'(d);
    if (wr) shadow[a] = DATA_W'(d);
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  function automatic int pat(input int a, input int pass);
    return (a * 37 + 5 + pass * 11) & 8'hFF;
  endfunction

  initial begin
    int c0, r0;
    for (int i = 0; i < WORDS; i++) begin model_mem[i] = '0; shadow[i] = '0; end
    for (int i = 0; i < ROWS; i++) ref_time[i] = 0;
    repeat (3) @(posedge clk);
    // R1: reset state
    @(negedge clk);
    chk(mem_ras_n && mem_cas_n && mem_we_n && mem_oe_n, "R1 strobes in reset", {mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n}, 4'hF);
    chk(!rsp_valid && !mem_dq_oe, "R1 no response or drive in reset", {rsp_valid, mem_dq_oe}, 0);
    @(posedge clk); #1 rst = 0;
    @(negedge clk);
    chk(req_ready && mem_ras_n && mem_cas_n, "R1 idle after reset", {req_ready, mem_ras_n, mem_cas_n}, 3'b111);
    @(posedge clk); #1;
    // R2/R4/R6: sequential writes (page hits inside each row)
    for (int a = 0; a < WORDS; a++) issue(1, a, pat(a, 0));
    // R3/R4: sequential reads
    for (int a = 0; a < WORDS; a++) issue(0, a, 0);
    // R4/R5: column-major reads, every access a row miss
    for (int c = 0; c < (1 << COL_W); c++)
      for (int r = 0; r < ROWS; r++) issue(0, (r << COL_W) | c, 0);
    // R2/R6: interleaved writes and reads across rows
    for (int i = 0; i < WORDS; i++) begin
      issue(1, (i * 5) & (WORDS - 1), pat(i, 1));
      issue(0, (i * 13 + 7) & (WORDS - 1), 0);
      issue(0, (i * 5) & (WORDS - 1), 0);
    end
    // R8: continuous same-row stream must not hold off refresh
    c0 = cyc; r0 = n_ref;
    for (int i = 0; i < 200; i++) issue(0, (3 << COL_W) | (i % (1 << COL_W)), 0);
    chk(n_ref - r0 >= (cyc - c0) / REF_INT - 1, "R8 refresh under streaming", n_ref - r0, (cyc - c0) / REF_INT - 1);
    // R7: idle period, every row refreshed within ROWS intervals
    repeat (ROWS * REF_INT + 2 * REF_INT) @(posedge clk);
    @(negedge clk);
    for (int r = 0; r < ROWS; r++)
      chk(cyc - ref_time[r] <= ROWS * REF_INT + 40, "R7 row refresh coverage", cyc - ref_time[r], ROWS * REF_INT + 40);
    chk(qh == qt && rh == rt, "R3 all requests served", (qt - qh) + (rt - rh), 0);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule